// File: doc/BRIEF.md
# Wait-for-interrupt cycle sequencer

This block steps a processor through the three bus cycles of its wait-for-interrupt instruction. It runs on one system clock. The `phase2` input is high during phase 2 of each processor cycle and low during phase 1. A processor cycle ends when `phase2` falls. The sequencer registers that boundary on the first system clock of the following phase 1, and the cycle indicator moves on at the end of that clock. The block samples `irq_n` and `rdy_in` on every clock of phase 2. The values held from the last phase-2 clock decide what happens at the boundary.

The stall is taken inside cycle 2, not after the instruction. If no interrupt is pending when phase 2 of cycle 2 begins, the block drives its RDY pull-down. The pull-down stays active until a cycle ends with an interrupt seen. Cycle 2 then runs once more with RDY free, cycle 3 follows, and a one-clock `done` pulse lets the next opcode fetch go ahead. A low IRQ level that is present when cycle 2 is judged skips the wait altogether. This holds even if the interrupt is masked elsewhere. A falling edge on NMI is held in a flag from the start of the instruction until `done`. A steady low NMI level has no effect.

Top module: `wfi_cycle_seq`

## Requirements
- R1: When `rst_n` is low at a clock edge, the block returns to idle: `cyc` = 0, `rdy_pd_n` = 1, `done` = 0, and the captured NMI edge is dropped. A later instruction with IRQ high therefore waits again.
- R2: The `cyc` encoding is 0 for idle and 1, 2 or 3 for the instruction cycle in progress. `start` in idle gives `cyc` = 1 after the next edge. Each later advance (1 to 2, 2 to 3, 3 to 0) happens on the first clock of phase 1 after `phase2` falls.
- R3: When `irq_n` is high and no NMI edge has been captured, `rdy_pd_n` is low on every clock of phase 2 of cycle 2. It is high during phase 1 of the first run of cycle 2. While waiting it stays low through every cycle boundary at which no interrupt is seen.
- R4: If `irq_n` is already low on the last phase-2 clock of cycle 2 and was never high during that phase 2, the pull-down is never driven. `done` appears 3 processor cycles after the cycle in which `start` arrived.
- R5: The pull-down is released on the cycle boundary that follows a phase 2 whose last clock saw `irq_n` low, and `rdy_pd_n` is high once that boundary is registered. Cycle 2 then repeats, cycle 3 follows, and `done` comes 3 processor cycles after the cycle in which the interrupt was seen.
- R6: A falling edge of `nmi_n` ends the wait in the same way as IRQ. This applies to an edge from the `start` clock onward, including one during cycle 1, which then skips the wait. An edge while idle and a steady low level are ignored.
- R7: The captured NMI edge is cleared together with `done`, so the next instruction waits if IRQ is high.
- R8: If `irq_n` goes high again during phase 2 of the repeated cycle 2, `rdy_pd_n` goes low in that same clock and the wait resumes.
- R9: `rdy_in` low on the last phase-2 clock holds the current cycle for one more processor cycle. `stall` is high whenever the own pull-down is active or `rdy_in` is low.
- R10: `done` is high for exactly one clock, in the clock where `cyc` returns from 3 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| phase2 | input | 1 | High in phase 2 of a processor cycle, low in phase 1 |
| start | input | 1 | Pulse when the wait opcode is decoded; taken only in idle |
| irq_n | input | 1 | Maskable interrupt request, active low, level |
| nmi_n | input | 1 | Non-maskable interrupt, active low, falling edge counts |
| rdy_in | input | 1 | Level seen on the shared RDY line |
| rdy_pd_n | output | 1 | Low enables the RDY pull-down |
| stall | output | 1 | Processor is held this clock |
| cyc | output | 2 | Instruction cycle: 0 idle, 1..3 cycle number |
| done | output | 1 | One-clock pulse allowing the next opcode fetch |

## Verification
The bench measures how many processor cycles pass from `start` to `done`. It does this with IRQ already pending, with IRQ or NMI arriving after the wait has begun, with NMI held low from before the instruction, and with RDY held low in different cycles. A design that advanced cycle 3 straight after release would finish one cycle early. A design that re-sampled the NMI level would wake on a steady low line. A design that kept the NMI flag past `done` would skip the wait of the next instruction. An interrupt that bounces high again in the repeated cycle 2 must pull RDY low in the same clock. A reset during a wait must free the line and drop a captured NMI edge, and the bench checks both at the ports.

// File: rtl/wfi_cycle_seq.sv
module wfi_cycle_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase2,
  input  logic       start,
  input  logic       irq_n,
  input  logic       nmi_n,
  input  logic       rdy_in,
  output logic       rdy_pd_n,
  output logic       stall,
  output logic [1:0] cyc,
  output logic       done
);

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_C1   = 2'd1,
    S_C2   = 2'd2,
    S_C3   = 2'd3
  } step_t;

  step_t st;
  logic  ph_q, nmi_q, irq_s, rdy_s, pd, nmi_seen;
  logic  cyc_end, nmi_fall, hold, wake, pd_on;

  assign cyc_end  = ph_q & ~phase2;
  assign nmi_fall = nmi_q & ~nmi_n;
  assign hold     = (st == S_C2) & phase2 & irq_n & ~nmi_seen;
  assign wake     = ~irq_s | nmi_seen;
  assign pd_on    = pd | hold;

  assign rdy_pd_n = ~pd_on;
  assign stall    = pd_on | ~rdy_in;
  assign cyc      = st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph_q     <= 1'b0;
      nmi_q    <= 1'b1;
      irq_s    <= 1'b1;
      rdy_s    <= 1'b1;
      pd       <= 1'b0;
      nmi_seen <= 1'b0;
      done     <= 1'b0;
    end else begin
      ph_q  <= phase2;
      nmi_q <= nmi_n;
      if (phase2) begin
        irq_s <= irq_n;
        rdy_s <= rdy_in;
      end
      done <= 1'b0;
      if (hold)
        pd <= 1'b1;
      if (nmi_fall && (st != S_IDLE || start))
        nmi_seen <= 1'b1;
      case (st)
        S_IDLE: if (start) st <= S_C1;
        S_C1:   if (cyc_end && rdy_s) st <= S_C2;
        S_C2: begin
          if (cyc_end) begin
            if (pd) begin
              if (wake) pd <= 1'b0;
            end else if (rdy_s) begin
              st <= S_C3;
            end
          end
        end
        S_C3: begin
          if (cyc_end && rdy_s) begin
            st       <= S_IDLE;
            done     <= 1'b1;
            nmi_seen <= 1'b0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/wfi_cycle_seq_chk.sv
module wfi_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       phase2,
  input logic       start,
  input logic       rdy_pd_n,
  input logic       done,
  input logic [1:0] cyc
);

  assert_pd_in_c2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_pd_n |-> cyc == 2'd2);

  assert_release_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_pd_n) |-> !phase2);

  assert_no_done_while_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_pd_n |=> !done);

  assert_done_one_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_c3_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cyc) == 2'd3 && cyc == 2'd0));

  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0 && !start) |=> cyc == 2'd0);

  assert_c1_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == 2'd1 |=> (cyc == 2'd1 || cyc == 2'd2));

  assert_c3_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc == 2'd3 |=> (cyc == 2'd3 || cyc == 2'd0));

endmodule

bind wfi_cycle_seq wfi_cycle_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .phase2   (phase2),
  .start    (start),
  .rdy_pd_n (rdy_pd_n),
  .done     (done),
  .cyc      (cyc)
);

// File: tb/wfi_cycle_seq_tb.sv
module wfi_cycle_seq_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, phase2, start, irq_n, nmi_n, rdy_in;
  logic       rdy_pd_n, stall, done;
  logic [1:0] cyc;

  wfi_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .phase2(phase2), .start(start),
    .irq_n(irq_n), .nmi_n(nmi_n), .rdy_in(rdy_in),
    .rdy_pd_n(rdy_pd_n), .stall(stall), .cyc(cyc), .done(done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int n, q;
  bit arm;
  bit c_pre_irq, c_pre_nmi;
  int c_irq_at, c_nmi_at, c_rdy_at, c_bounce;
  logic irq_lvl, nmi_lvl;

  // {pre_irq_low, pre_nmi_low, irq_at, nmi_at, rdy_at, bounce, expected cycles}
  localparam int NV = 12;
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 1'b0, 8'd255, 8'd255, 8'd255, 8'd0, 8'd3},
    {1'b0, 1'b0, 8'd1,   8'd255, 8'd255, 8'd0, 8'd4},
    {1'b0, 1'b0, 8'd5,   8'd255, 8'd255, 8'd0, 8'd8},
    {1'b0, 1'b0, 8'd255, 8'd3,   8'd255, 8'd0, 8'd6},
    {1'b0, 1'b0, 8'd255, 8'd0,   8'd255, 8'd0, 8'd3},
    {1'b0, 1'b0, 8'd2,   8'd255, 8'd255, 8'd0, 8'd5},
    {1'b0, 1'b1, 8'd4,   8'd255, 8'd255, 8'd0, 8'd7},
    {1'b0, 1'b0, 8'd2,   8'd255, 8'd255, 8'd3, 8'd9},
    {1'b1, 1'b0, 8'd255, 8'd255, 8'd0,   8'd0, 8'd4},
    {1'b1, 1'b0, 8'd255, 8'd255, 8'd2,   8'd0, 8'd4},
    {1'b0, 1'b0, 8'd2,   8'd255, 8'd3,   8'd0, 8'd6},
    {1'b0, 1'b0, 8'd1,   8'd1,   8'd255, 8'd0, 8'd4}
  };

  function automatic string tag_of(int i);
    case (i)
      0:         return "R4 pending IRQ";
      1, 2, 11:  return "R5 IRQ wake";
      3, 4:      return "R6 NMI edge";
      5:         return "R7 NMI flag cleared by done";
      6:         return "R6 steady NMI low";
      7:         return "R8 IRQ bounce";
      default:   return "R9 external RDY";
    endcase
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic apply();
    if (n < 0) begin
      irq_lvl = !c_pre_irq;
      nmi_lvl = !c_pre_nmi;
    end
    if (n == c_irq_at && q == 3) irq_lvl = 1'b0;
    if (c_bounce != 0 && n == c_irq_at + 1 && q == 2) irq_lvl = 1'b1;
    if (c_bounce != 0 && n == c_irq_at + 1 + c_bounce && q == 3) irq_lvl = 1'b0;
    if (n == c_nmi_at && q == 3) nmi_lvl = 1'b0;
    phase2 = (q >= 2);
    start  = arm && n == 0 && q == 1;
    irq_n  = irq_lvl;
    nmi_n  = nmi_lvl;
    rdy_in = !(n == c_rdy_at && q >= 2);
  endtask

  task automatic tick();
    apply();
    @(negedge clk);
  endtask

  task automatic advance();
    if (q == 3) begin
      q = 0;
      n++;
    end else begin
      q++;
    end
  endtask

  task automatic set_none();
    c_pre_irq = 0; c_pre_nmi = 0;
    c_irq_at = 255; c_nmi_at = 255; c_rdy_at = 255; c_bounce = 0;
  endtask

  task automatic run_vec(input logic [41:0] v, input string tag);
    int meas = -1, mq = -1, exp;
    int cyc_done = -1, done_after = -1;
    int pd_w3 = -1, pd_w0 = -1, b1 = -1, b2 = -1, st2 = -1;
    int t1 = -1, t2 = -1, t3 = -1;
    bit fin;
    c_pre_irq = v[41];
    c_pre_nmi = v[40];
    c_irq_at  = int'(v[39:32]);
    c_nmi_at  = int'(v[31:24]);
    c_rdy_at  = int'(v[23:16]);
    c_bounce  = int'(v[15:8]);
    exp       = int'(v[7:0]);
    arm = 1; n = -1; q = 0;
    while (1) begin
      tick();
      if (done && meas < 0) begin meas = n; mq = q; end
      if (meas >= 0 && n == meas && q == 0) cyc_done = cyc;
      if (meas >= 0 && n == meas && q == 1) done_after = done;
      if (n == 0 && q == 1) t1 = cyc;
      if (n == 1 && q == 0) t2 = cyc;
      if (n == 2 && q == 0) t3 = cyc;
      if (n == c_irq_at && q == 3) pd_w3 = rdy_pd_n;
      if (n == c_irq_at + 1 && q == 0) pd_w0 = rdy_pd_n;
      if (n == c_irq_at + 1 && q == 1) b1 = rdy_pd_n;
      if (n == c_irq_at + 1 && q == 2) b2 = rdy_pd_n;
      if (n == c_rdy_at && q == 2) st2 = stall;
      fin = (q == 3) && (meas >= 0 || n >= 40);
      advance();
      if (fin) break;
    end
    arm = 0;
    chk({tag, " done cycle count"}, meas, exp);
    chk({tag, " done on phase-1 boundary clock"}, mq, 0);
    chk({tag, " R10 cyc back to 0 with done"}, cyc_done, 0);
    chk({tag, " R10 done lasts one clock"}, done_after, 0);
    if (c_pre_irq && c_rdy_at == 255) begin
      chk("R2 cyc after start", t1, 1);
      chk("R2 cyc after first boundary", t2, 2);
      chk("R2 cyc after second boundary", t3, 3);
    end
    if (!c_pre_irq && c_irq_at != 255 && c_irq_at >= 2) begin
      chk({tag, " R5 held until boundary"}, pd_w3, 0);
      chk({tag, " R5 released at boundary"}, pd_w0, 1);
    end
    if (c_bounce != 0) begin
      chk("R8 free in phase 1 of repeated cycle 2", b1, 1);
      chk("R8 pull-down again on bounce", b2, 0);
    end
    if (c_rdy_at != 255) chk("R9 stall with RDY low", st2, 1);
  endtask

  initial begin
    rst_n = 1'b0; arm = 0; n = 100; q = 0;
    irq_lvl = 1'b1; nmi_lvl = 1'b1;
    set_none();
    repeat (8) begin tick(); advance(); end
    chk("R1 reset cyc", cyc, 0);
    chk("R1 reset rdy_pd_n", rdy_pd_n, 1);
    chk("R1 reset done", done, 0);
    chk("R1 reset stall", stall, 0);
    rst_n = 1'b1;
    repeat (4) begin tick(); advance(); end

    for (int i = 0; i < NV; i++) begin
      run_vec(VEC[i], tag_of(i));
      set_none();
      n = 100;
      repeat (4) begin tick(); advance(); end
    end

    // wait with no interrupt, then reset mid-wait
    set_none();
    arm = 1; n = -1; q = 0;
    repeat (24) begin
      if (n == 4) rst_n = 1'b0;
      tick();
      if (n == 1 && q == 1) chk("R3 pull-down off in phase 1 of cycle 2", rdy_pd_n, 1);
      if (n == 1 && q == 2) begin
        chk("R3 pull-down at phase 2 of cycle 2", rdy_pd_n, 0);
        chk("R9 stall follows own pull-down", stall, 1);
      end
      if (n == 3 && q == 2) begin
        chk("R3 still in cycle 2 while waiting", cyc, 2);
        chk("R3 pull-down held while waiting", rdy_pd_n, 0);
      end
      if (n == 4 && q == 0) begin
        chk("R1 reset mid-wait cyc", cyc, 0);
        chk("R1 reset mid-wait frees RDY", rdy_pd_n, 1);
      end
      advance();
    end
    rst_n = 1'b1; arm = 0;

    // capture an NMI edge, reset, next instruction must wait
    set_none();
    c_nmi_at = 0;
    arm = 1; n = -1; q = 0;
    repeat (16) begin
      if (n == 2) rst_n = 1'b0;
      tick();
      if (n == 2 && q == 3) chk("R1 reset during run cyc", cyc, 0);
      advance();
    end
    rst_n = 1'b1; arm = 0;
    set_none();
    run_vec({1'b0, 1'b0, 8'd3, 8'd255, 8'd255, 8'd0, 8'd6}, "R1 NMI flag dropped by reset");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule